// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the command side of a serial flash device, seen from the single-data-line SPI bus (mode 0). Each transaction opens when chip select falls. The block samples an 8-bit opcode on rising serial clock edges and decodes it. Where the opcode needs one, it collects a 24-bit address, most significant byte first. In the read phases it shifts bytes out on falling edges.

The block holds the write-enable latch and reflects the busy flag of the array. It turns accepted program, erase and status-write commands into single-cycle requests toward an external array model. That model supplies read bytes combinationally from `mem_addr`, stores the 16 status bits, and raises `arr_busy` while an operation runs.

The bus pins are sampled with the system clock `clk` through a synchronizer. Edges are detected internally, so the serial clock must run well below `clk`.

Top module: `flash_cmd_front`

## Requirements
- R1: After reset, `spi_miso_oe` is low, no request is issued, and a 05h read returns write-enable (bit 1) and busy (bit 0) both as 0.
- R2: Opcode 06h sets the write-enable latch and opcode 04h clears it. The latch is visible as bit 1 of the byte returned by opcode 05h.
- R3: Opcode 05h returns `{sr_q[7:2], write-enable, arr_busy}` and opcode 35h returns `sr_q[15:8]`. Both are sent MSB first, and the same byte repeats for as long as clocks continue.
- R4: Opcode 01h with the latch set may end with chip select rising after exactly one or exactly two data bytes. After one byte it issues `sr_wr` with `sr_wdata = {sr_q[15:8], byte1}`. After two bytes it issues `sr_wr` with `{byte2, byte1}`. Any other ending issues nothing.
- R5: With the latch clear, opcodes 02h, 20h, 52h, D8h, C7h, 60h and 01h issue no request.
- R6: While `arr_busy` is 1, every opcode other than 05h and 35h has no effect. The latch is unchanged and DO is never driven.
- R7: The write-enable latch clears when `arr_busy` falls.
- R8: Opcode 03h followed by a 24-bit address returns bytes MSB first on falling clock edges. Byte k comes from address+k, wrapping at 24 bits, until chip select rises.
- R9: Opcode 0Bh behaves as 03h, except that 8 dummy clocks follow the address before data starts.
- R10: Opcode 02h with the latch set issues one `wr_req` per received data byte, with `req_addr`/`wr_data`. The low 8 address bits advance and wrap inside the 256-byte page, and the upper 16 bits never change.
- R11: With the latch set, an erase is requested at the rise of chip select only if the transaction ended exactly after the address, or after the opcode for whole-array erase. The request carries `ers_kind` 0 for 20h (4 KiB), 1 for 52h (32 KiB), 2 for D8h (64 KiB) and 3 for C7h/60h (whole array), with `req_addr` = the address. At most one request pulses per cycle.
- R12: `spi_miso_oe` is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` |
| mem_addr | output | 24 | Read address to the array model |
| mem_rdata | input | 8 | Byte at `mem_addr` |
| wr_req | output | 1 | One-cycle program-byte request |
| req_addr | output | 24 | Address of program or erase request |
| wr_data | output | 8 | Byte to program |
| ers_req | output | 1 | One-cycle erase request |
| ers_kind | output | 2 | Erase size code |
| sr_q | input | 16 | Stored status bits |
| sr_wr | output | 1 | One-cycle status-write request |
| sr_wdata | output | 16 | New status value |
| arr_busy | input | 1 | Array operation in progress |

## Verification
Each bus pin passes two synchronizer stages and one edge register. A falling clock edge therefore updates `spi_miso` about four `clk` cycles later. The bench holds every serial clock phase for eight cycles and samples DO at the end of the low phase, just before the next rising edge. Requests appear about four cycles after chip select rises, or after the rising edge that completes a byte. The bench counts them in a monitor and checks the counts only after chip select has been high for twelve cycles.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

  localparam logic [7:0] OPC_WR_EN   = 8'h06;
  localparam logic [7:0] OPC_WR_DIS  = 8'h04;
  localparam logic [7:0] OPC_RD_SR1  = 8'h05;
  localparam logic [7:0] OPC_RD_SR2  = 8'h35;
  localparam logic [7:0] OPC_WR_SR   = 8'h01;
  localparam logic [7:0] OPC_READ    = 8'h03;
  localparam logic [7:0] OPC_FREAD   = 8'h0B;
  localparam logic [7:0] OPC_PROG    = 8'h02;
  localparam logic [7:0] OPC_ER4K    = 8'h20;
  localparam logic [7:0] OPC_ER32K   = 8'h52;
  localparam logic [7:0] OPC_ER64K   = 8'hD8;
  localparam logic [7:0] OPC_ERALL_A = 8'hC7;
  localparam logic [7:0] OPC_ERALL_B = 8'h60;

  typedef enum logic [3:0] {
    ST_OPC,   // collecting opcode
    ST_ADR,   // collecting address bytes
    ST_DUM,   // dummy byte of fast read
    ST_RD,    // array data out
    ST_SR,    // status byte out
    ST_PGM,   // program data in
    ST_WSR,   // status bytes in
    ST_ARM,   // erase armed, waiting for chip select rise
    ST_DROP   // ignore rest of transaction
  } fe_state_t;

  typedef enum logic [1:0] {
    ER_4K  = 2'd0,
    ER_32K = 2'd1,
    ER_64K = 2'd2,
    ER_ALL = 2'd3
  } erase_kind_t;

endpackage

// File: rtl/fe_pin_sync.sv
module fe_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sclk_i,
  input  logic mosi_i,
  output logic cs_n_o,
  output logic cs_rise,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic mosi_o
);
  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] RST_VAL = 3'b100;  // {cs_n, sclk, mosi}

  logic [NPIN-1:0] pin_raw;
  logic [NPIN-1:0] pin_s;
  logic            sclk_d;
  logic            cs_d;

  assign pin_raw = {cs_n_i, sclk_i, mosi_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], pin_raw[g]};
    end
    assign pin_s[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= pin_s[1];
      cs_d   <= pin_s[2];
    end
  end

  assign cs_n_o    = pin_s[2];
  assign cs_rise   = pin_s[2] & ~cs_d;
  assign sclk_rise = pin_s[1] & ~sclk_d;
  assign sclk_fall = ~pin_s[1] & sclk_d;
  assign mosi_o    = pin_s[0];
endmodule

// File: rtl/fe_tx_shift.sv
module fe_tx_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              fall,
  input  logic [BYTE_W-1:0] load_data,
  output logic              dout,
  output logic              drive,
  output logic              byte_end
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic [BYTE_W-2:0] sh, sh_n;
  logic [CW-1:0]     cnt, cnt_n;
  logic              dout_n, drive_n;

  always_comb begin
    sh_n    = sh;
    cnt_n   = cnt;
    dout_n  = dout;
    drive_n = drive;
    if (!en) begin
      cnt_n   = '0;
      drive_n = 1'b0;
      dout_n  = 1'b0;
    end else if (fall) begin
      drive_n = 1'b1;
      cnt_n   = cnt + CW'(1);
      if (cnt == '0) begin
        dout_n = load_data[BYTE_W-1];
        sh_n   = load_data[BYTE_W-2:0];
      end else begin
        dout_n = sh[BYTE_W-2];
        sh_n   = {sh[BYTE_W-3:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '0;
      cnt   <= '0;
      dout  <= 1'b0;
      drive <= 1'b0;
    end else begin
      sh    <= sh_n;
      cnt   <= cnt_n;
      dout  <= dout_n;
      drive <= drive_n;
    end
  end

  assign byte_end = en & fall & (cnt == LAST);

  // R12: output enable drops one cycle after the phase ends
  a_r12_drive_follows_en: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !drive);
endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
  import flash_fe_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int PAGE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              wr_req,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        wr_data,
  output logic              ers_req,
  output logic [1:0]        ers_kind,
  input  logic [15:0]       sr_q,
  output logic              sr_wr,
  output logic [15:0]       sr_wdata,
  input  logic              arr_busy
);
  localparam int CNT_W = 3;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] ADR_LAST = CNT_W'(ADDR_W / 8);
  localparam logic [CNT_W-1:0] WSR_ONE  = CNT_W'(2);
  localparam logic [CNT_W-1:0] WSR_TWO  = CNT_W'(3);

  logic cs_n_s, cs_rise, sclk_rise, sclk_fall, mosi_s;

  fe_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .cs_n_i(spi_cs_n), .sclk_i(spi_sclk), .mosi_i(spi_mosi),
    .cs_n_o(cs_n_s), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_o(mosi_s)
  );

  fe_state_t         state, state_n;
  logic [7:0]        op, op_n;
  logic [2:0]        bcnt, bcnt_n;
  logic [CNT_W-1:0]  nbytes, nbytes_n;
  logic [6:0]        shin, shin_n;
  logic [ADDR_W-1:0] addr, addr_n;
  logic              wel, wel_n;
  logic              busy_q;
  logic              sr_sel, sr_sel_n;
  logic [7:0]        wb1, wb1_n, wb2, wb2_n;
  logic              wr_req_n, ers_req_n, sr_wr_n;
  logic [ADDR_W-1:0] req_addr_n;
  logic [7:0]        wr_data_n;
  logic [1:0]        ers_kind_n;
  logic [15:0]       sr_wdata_n;

  logic       active, bit_rise, byte_last;
  logic [7:0] rx_byte, sr1_view, tx_load;
  logic       tx_en, tx_end;

  assign active    = ~cs_n_s;
  assign bit_rise  = active & sclk_rise;
  assign byte_last = (bcnt == 3'd7);
  assign rx_byte   = {shin, mosi_s};
  assign sr1_view  = {sr_q[7:2], wel, arr_busy};
  assign tx_en     = active & ((state == ST_RD) | (state == ST_SR));
  assign tx_load   = (state == ST_SR) ? (sr_sel ? sr_q[15:8] : sr1_view) : mem_rdata;

  fe_tx_shift #(.BYTE_W(8)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .fall(sclk_fall),
    .load_data(tx_load), .dout(spi_miso), .drive(spi_miso_oe), .byte_end(tx_end)
  );

  always_comb begin
    state_n    = state;
    op_n       = op;
    bcnt_n     = bcnt;
    nbytes_n   = nbytes;
    shin_n     = shin;
    addr_n     = addr;
    wel_n      = wel;
    sr_sel_n   = sr_sel;
    wb1_n      = wb1;
    wb2_n      = wb2;
    wr_req_n   = 1'b0;
    ers_req_n  = 1'b0;
    sr_wr_n    = 1'b0;
    req_addr_n = req_addr;
    wr_data_n  = wr_data;
    ers_kind_n = ers_kind;
    sr_wdata_n = sr_wdata;

    if (busy_q && !arr_busy) wel_n = 1'b0;

    if (cs_n_s) begin
      state_n  = ST_OPC;
      bcnt_n   = '0;
      nbytes_n = '0;
      if (cs_rise && bcnt == '0) begin
        if (state == ST_ARM) begin
          ers_req_n  = 1'b1;
          req_addr_n = addr;
        end
        if (state == ST_WSR && nbytes == WSR_ONE) begin
          sr_wr_n    = 1'b1;
          sr_wdata_n = {sr_q[15:8], wb1};
        end
        if (state == ST_WSR && nbytes == WSR_TWO) begin
          sr_wr_n    = 1'b1;
          sr_wdata_n = {wb2, wb1};
        end
      end
    end else begin
      if (tx_end && state == ST_RD) addr_n = addr + ADDR_W'(1);
      if (bit_rise) begin
        bcnt_n = bcnt + 3'd1;
        shin_n = {shin[5:0], mosi_s};
        if (byte_last) begin
          if (nbytes != CNT_MAX) nbytes_n = nbytes + CNT_W'(1);
          unique case (state)
            ST_OPC: begin
              op_n = rx_byte;
              if (arr_busy && rx_byte != OPC_RD_SR1 && rx_byte != OPC_RD_SR2) begin
                state_n = ST_DROP;
              end else begin
                case (rx_byte)
                  OPC_WR_EN:  begin wel_n = 1'b1; state_n = ST_DROP; end
                  OPC_WR_DIS: begin wel_n = 1'b0; state_n = ST_DROP; end
                  OPC_RD_SR1: begin sr_sel_n = 1'b0; state_n = ST_SR; end
                  OPC_RD_SR2: begin sr_sel_n = 1'b1; state_n = ST_SR; end
                  OPC_READ, OPC_FREAD: state_n = ST_ADR;
                  OPC_PROG, OPC_ER4K, OPC_ER32K, OPC_ER64K:
                    state_n = wel ? ST_ADR : ST_DROP;
                  OPC_ERALL_A, OPC_ERALL_B: begin
                    state_n    = wel ? ST_ARM : ST_DROP;
                    ers_kind_n = ER_ALL;
                  end
                  OPC_WR_SR: state_n = wel ? ST_WSR : ST_DROP;
                  default:   state_n = ST_DROP;
                endcase
              end
            end
            ST_ADR: begin
              addr_n = {addr[ADDR_W-9:0], rx_byte};
              if (nbytes == ADR_LAST) begin
                case (op)
                  OPC_READ:  state_n = ST_RD;
                  OPC_FREAD: state_n = ST_DUM;
                  OPC_PROG:  state_n = ST_PGM;
                  OPC_ER4K:  begin state_n = ST_ARM; ers_kind_n = ER_4K;  end
                  OPC_ER32K: begin state_n = ST_ARM; ers_kind_n = ER_32K; end
                  OPC_ER64K: begin state_n = ST_ARM; ers_kind_n = ER_64K; end
                  default:   state_n = ST_DROP;
                endcase
              end
            end
            ST_DUM: state_n = ST_RD;
            ST_PGM: begin
              wr_req_n   = 1'b1;
              req_addr_n = addr;
              wr_data_n  = rx_byte;
              addr_n[PAGE_W-1:0] = addr[PAGE_W-1:0] + PAGE_W'(1);
            end
            ST_WSR: begin
              if (nbytes == CNT_W'(1))      wb1_n = rx_byte;
              else if (nbytes == WSR_ONE)   wb2_n = rx_byte;
              else                          state_n = ST_DROP;
            end
            ST_ARM:  state_n = ST_DROP;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_OPC;
      op       <= '0;
      bcnt     <= '0;
      nbytes   <= '0;
      shin     <= '0;
      addr     <= '0;
      wel      <= 1'b0;
      busy_q   <= 1'b0;
      sr_sel   <= 1'b0;
      wb1      <= '0;
      wb2      <= '0;
      wr_req   <= 1'b0;
      ers_req  <= 1'b0;
      sr_wr    <= 1'b0;
      req_addr <= '0;
      wr_data  <= '0;
      ers_kind <= '0;
      sr_wdata <= '0;
    end else begin
      state    <= state_n;
      op       <= op_n;
      bcnt     <= bcnt_n;
      nbytes   <= nbytes_n;
      shin     <= shin_n;
      addr     <= addr_n;
      wel      <= wel_n;
      busy_q   <= arr_busy;
      sr_sel   <= sr_sel_n;
      wb1      <= wb1_n;
      wb2      <= wb2_n;
      wr_req   <= wr_req_n;
      ers_req  <= ers_req_n;
      sr_wr    <= sr_wr_n;
      req_addr <= req_addr_n;
      wr_data  <= wr_data_n;
      ers_kind <= ers_kind_n;
      sr_wdata <= sr_wdata_n;
    end
  end

  assign mem_addr = addr;

  // R11: never more than one request at a time
  a_r11_one_req: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wr_req, ers_req, sr_wr}) <= 1);

  // R11/R4: erase and status write fire only on a chip select rise
  a_r4_commit_on_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (ers_req || sr_wr) |-> $past(cs_rise));

  // R10: a program byte never leaves the page being filled
  a_r10_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (req_addr[ADDR_W-1:PAGE_W] == mem_addr[ADDR_W-1:PAGE_W]));

  // R6: the latch is only set from opcode decode while not busy
  a_r6_wel_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> ($past(state) == ST_OPC && !$past(arr_busy)));

  // R12: chip select held high keeps DO released
  a_r12_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_s && $past(cs_n_s) && $past(cs_n_s, 2)) |-> !spi_miso_oe);
endmodule

// File: tb/sim_flash_cmd_front.sv
module sim_flash_cmd_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
  logic        spi_miso, spi_miso_oe;
  logic [23:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        wr_req, ers_req, sr_wr;
  logic [23:0] req_addr;
  logic [7:0]  wr_data;
  logic [1:0]  ers_kind;
  logic [15:0] sr_q, sr_wdata;
  logic        arr_busy = 1'b0;

  int nchk = 0, nfail = 0;
  int wcnt = 0, ecnt = 0, scnt = 0;
  logic [31:0] wlog [16];
  logic [25:0] last_ers;
  logic [31:0] rx_sh;
  logic        oe_any;
  logic [7:0]  rxb [8];

  always #5 clk = ~clk;

  function automatic logic [7:0] memf(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction
  assign mem_rdata = memf(mem_addr);

  flash_cmd_front u0 (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .wr_req(wr_req),
    .req_addr(req_addr), .wr_data(wr_data), .ers_req(ers_req),
    .ers_kind(ers_kind), .sr_q(sr_q), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
    .arr_busy(arr_busy)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      sr_q <= 16'h9AF0;
    end else begin
      if (wr_req) begin
        wlog[wcnt[3:0]] <= {req_addr, wr_data};
        wcnt <= wcnt + 1;
      end
      if (ers_req) begin
        last_ers <= {ers_kind, req_addr};
        ecnt <= ecnt + 1;
      end
      if (sr_wr) begin
        sr_q <= sr_wdata;
        scnt <= scnt + 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spi_bits(input logic [31:0] d, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      spi_mosi = d[n-1-i];
      repeat (7) @(negedge clk);
      rx_sh = {rx_sh[30:0], spi_miso};
      oe_any = oe_any | spi_miso_oe;
      spi_sclk = 1'b1;
      repeat (8) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic cs_lo();
    @(negedge clk);
    spi_cs_n = 1'b0;
    oe_any = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (4) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] d, input int n);
    cs_lo();
    spi_bits(d, n);
    cs_hi();
  endtask

  task automatic rd_sr(input logic [7:0] opc, input int n);
    cs_lo();
    spi_bits({24'h0, opc}, 8);
    for (int i = 0; i < n; i++) begin
      spi_bits(32'h0, 8);
      rxb[i] = rx_sh[7:0];
    end
    cs_hi();
  endtask

  task automatic rd_mem(input logic fast, input logic [23:0] a, input int n);
    cs_lo();
    spi_bits({24'h0, fast ? 8'h0B : 8'h03}, 8);
    spi_bits({8'h0, a}, 24);
    if (fast) spi_bits(32'h0, 8);
    for (int i = 0; i < n; i++) begin
      spi_bits(32'h0, 8);
      rxb[i] = rx_sh[7:0];
    end
    cs_hi();
  endtask

  // {fast[31:28], byte count[27:24], address[23:0]}
  localparam logic [31:0] RVEC [6] = '{
    32'h03000000, 32'h040000FE, 32'h130012FF,
    32'h02FFFFFF, 32'h15ABCDEF, 32'h010F0F0F
  };

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int w0, e0, s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 oe after reset", 32'(spi_miso_oe), 32'h0);
    check("R1 no requests", 32'(wcnt + ecnt + scnt), 32'h0);
    rd_sr(8'h05, 2);
    check("R1 R3 sr1 byte0", 32'(rxb[0]), 32'hF0);
    check("R3 sr1 repeats", 32'(rxb[1]), 32'hF0);
    rd_sr(8'h35, 2);
    check("R3 sr2 byte0", 32'(rxb[0]), 32'h9A);
    check("R3 sr2 repeats", 32'(rxb[1]), 32'h9A);
    check("R12 oe low after cs high", 32'(spi_miso_oe), 32'h0);

    // R2 latch set and clear
    send(32'h06, 8);
    rd_sr(8'h05, 1);
    check("R2 wel set", 32'(rxb[0]), 32'hF2);
    send(32'h04, 8);
    rd_sr(8'h05, 1);
    check("R2 wel cleared", 32'(rxb[0]), 32'hF0);

    // R5 write-class opcodes without latch
    send(32'h20001000, 32);
    send(32'hC7, 8);
    send(32'h01AA, 16);
    cs_lo(); spi_bits(32'h02000010, 32); spi_bits(32'h55, 8); cs_hi();
    check("R5 no requests without wel", 32'(wcnt + ecnt + scnt), 32'h0);

    // R11 erase kinds and exact ending
    send(32'h06, 8);
    send(32'h20012345, 32);
    check("R11 4K count", 32'(ecnt), 32'd1);
    check("R11 4K kind/addr", 32'(last_ers), {6'h0, 2'd0, 24'h012345});
    send(32'h52ABCDEF, 32);
    check("R11 32K kind/addr", 32'(last_ers), {6'h0, 2'd1, 24'hABCDEF});
    send(32'hD8070000, 32);
    check("R11 64K kind/addr", 32'(last_ers), {6'h0, 2'd2, 24'h070000});
    send(32'hC7, 8);
    check("R11 whole C7 kind", 32'(last_ers[25:24]), 32'd3);
    send(32'h60, 8);
    check("R11 whole 60 count", 32'(ecnt), 32'd5);
    cs_lo(); spi_bits(32'h20000100, 32); spi_bits(32'h5, 3); cs_hi();
    cs_lo(); spi_bits(32'hC7, 8); spi_bits(32'h0, 8); cs_hi();
    send(32'h20000, 20);
    check("R11 misaligned end ignored", 32'(ecnt), 32'd5);

    // R6 busy blocks, R7 latch clears on busy fall
    @(negedge clk); arr_busy = 1'b1;
    rd_sr(8'h05, 1);
    check("R6 sr1 while busy", 32'(rxb[0]), 32'hF3);
    send(32'h04, 8);
    rd_sr(8'h05, 1);
    check("R6 04 ignored while busy", 32'(rxb[0]), 32'hF3);
    rd_mem(1'b0, 24'h000040, 2);
    check("R6 read ignored while busy", 32'(oe_any), 32'h0);
    w0 = ecnt;
    send(32'h20000200, 32);
    check("R6 erase ignored while busy", 32'(ecnt), 32'(w0));
    @(negedge clk); arr_busy = 1'b0;
    repeat (4) @(negedge clk);
    rd_sr(8'h05, 1);
    check("R7 wel cleared on busy fall", 32'(rxb[0]), 32'hF0);

    // R10 page program with wrap inside page
    send(32'h06, 8);
    w0 = wcnt;
    cs_lo();
    spi_bits(32'h021234FE, 32);
    spi_bits(32'h11223344, 32);
    cs_hi();
    check("R10 byte count", 32'(wcnt - w0), 32'd4);
    check("R10 byte0", wlog[w0[3:0]],        32'h1234FE11);
    check("R10 byte1", wlog[4'(w0 + 1)],     32'h1234FF22);
    check("R10 byte2 wraps", wlog[4'(w0 + 2)], 32'h12340033);
    check("R10 byte3", wlog[4'(w0 + 3)],     32'h12340144);

    // R4 status write boundaries
    s0 = scnt;
    send(32'h0155, 16);
    check("R4 one byte write", 32'(sr_q), 32'h9A55);
    send(32'h016677, 24);
    check("R4 two byte write", 32'(sr_q), 32'h7766);
    send(32'h01ABC, 20);
    send(32'h01010203, 32);
    check("R4 bad endings ignored", 32'(scnt - s0), 32'd2);
    e0 = ecnt;
    check("R4 no stray erase", 32'(ecnt), 32'(e0));

    // R8 R9 read vectors
    for (int v = 0; v < 6; v++) begin
      logic fast;
      int   n;
      fast = RVEC[v][28];
      n    = int'(RVEC[v][27:24]);
      rd_mem(fast, RVEC[v][23:0], n);
      for (int i = 0; i < n; i++) begin
        check(fast ? "R9 fast read byte" : "R8 read byte",
              32'(rxb[i]), 32'(memf(RVEC[v][23:0] + 24'(i))));
      end
      check("R12 oe released", 32'(spi_miso_oe), 32'h0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule